// File: doc/BRIEF.md
# PHY Event Interrupt Status Unit

This block gathers receive-side link events from an Ethernet PHY. It latches each one into a 16-bit interrupt status word and holds an interrupt request high while any latched bit is set. The three link strobes are unstable carrier, link status change and descrambler lock change. Reading the status word through the simple register port returns the latched bits and clears them.

Three 16-bit event counters tally disconnects, false carriers and receive errors. Each counter can be read through the same port, and each is cleared by that read. When a counter's top bit goes from 0 to 1, it latches its own status bit. This warns management software well before the count runs out. The false-carrier counter stops at its ceiling. The other two counters wrap around to zero.

A frame checker watches decoded 100 Mb/s symbol classes. It flags a frame that ends early: two IDLE symbols in a row after a start-of-stream, with no end-of-stream delimiter before them.

Top module: `phy_irq_unit`

## Requirements
- R1: Address 11h returns the status word. Bit 15 is unstable link, bit 14 is link change, bit 13 is lock change, bit 12 is premature end, bit 11 is the disconnect counter's top bit, bit 10 is the false-carrier counter's top bit and bit 9 is the receive-error counter's top bit. Bits 8..0 read 0, and any address other than 11h, 12h, 13h or 15h reads 0.
- R2: Read data is combinational while `rd_i` is high. A read of 11h clears every status bit at that clock edge. `irq_o` is high exactly when some status bit is set.
- R3: A one-cycle strobe on `cim_unstable_i`, `link_chg_i` or `lock_chg_i` sets bit 15, 14 or 13 at the next clock edge. Strobes in the same cycle combine their bits.
- R4: An event that lands in the same cycle as a status read is kept. That read returns the old value, and the bit is set for the next read.
- R5: Premature-end detection is active only when `speed100_i` is high and `sym_valid_i` is high. The `sym_class_i` codes are: 1 = data, 2 = IDLE, 3 = start-of-stream, 4 = end-of-stream, and any other value has no effect. Start-of-stream arms the checker. Two consecutive IDLEs while armed set bit 12 at the edge of the second IDLE and disarm the checker. A data symbol restarts the IDLE run. End-of-stream disarms the checker.
- R6: The disconnect counter (12h), false-carrier counter (13h) and receive-error counter (15h) are 16 bits wide and add one per strobe cycle. Reading a counter clears it. A strobe in the same cycle as that read leaves the counter at 1.
- R7: A counter's top bit going from 0 to 1 sets status bit 11, 10 or 9 one edge after the count reaches 8000h. A top bit that stays high does not set the status bit again after a read.
- R8: The false-carrier counter holds at FFFFh. The disconnect and receive-error counters wrap from FFFFh to 0000h.
- R9: After reset the status word, all counters and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cim_unstable_i | input | 1 | Carrier integrity monitor saw an unstable link |
| link_chg_i | input | 1 | Link status changed |
| lock_chg_i | input | 1 | Descrambler lock state changed |
| disc_evt_i | input | 1 | Disconnect event strobe |
| fcar_evt_i | input | 1 | False carrier event strobe |
| rxerr_evt_i | input | 1 | Receive error event strobe |
| speed100_i | input | 1 | 100 Mb/s mode |
| sym_valid_i | input | 1 | Symbol class is valid this cycle |
| sym_class_i | input | 3 | Decoded symbol class |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register address |
| rdata_o | output | 16 | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Latencies differ by result:
- Read data is valid in the same cycle as `rd_i`.
- A link strobe, or the second IDLE of an early-ending frame, appears in the status word one edge later.
- A counter top-bit warning needs two edges: one for the count to reach 8000h and one for the edge detector.

The bench drives inputs at falling edges and samples read data just after driving `rd_i`. It waits two full cycles after the last counter strobe before reading status. Long counter runs drive all three strobes together, so one pass covers the top-bit event, the no-repeat case, saturation and wrap-around.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADDR_STAT  = 5'h11;
  localparam logic [ADDR_W-1:0] ADDR_DISC  = 5'h12;
  localparam logic [ADDR_W-1:0] ADDR_FCAR  = 5'h13;
  localparam logic [ADDR_W-1:0] ADDR_RXERR = 5'h15;

  localparam int BIT_CIM   = 15;
  localparam int BIT_LINK  = 14;
  localparam int BIT_LOCK  = 13;
  localparam int BIT_PEND  = 12;
  localparam int BIT_DISC  = 11;
  localparam int BIT_FCAR  = 10;
  localparam int BIT_RXERR = 9;

  typedef enum logic [2:0] {
    SYM_NONE = 3'd0,
    SYM_DATA = 3'd1,
    SYM_IDLE = 3'd2,
    SYM_SSD  = 3'd3,
    SYM_ESD  = 3'd4
  } sym_class_e;
endpackage

// File: rtl/phy_evt_counter.sv
module phy_evt_counter #(
  parameter int W   = 16,
  parameter bit SAT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         top_set_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, base, cnt_d;
  logic         msb_q;

  always_comb begin
    base  = clr_i ? '0 : cnt_q;
    cnt_d = base;
    if (inc_i) begin
      if (SAT && base == CNT_MAX) cnt_d = base;
      else                        cnt_d = base + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      msb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      msb_q <= cnt_q[W-1];
    end
  end

  assign cnt_o     = cnt_q;
  assign top_set_o = cnt_q[W-1] & ~msb_q;

  a_r6_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !inc_i |=> cnt_q == '0);
  a_r6_read_and_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && inc_i |=> cnt_q == W'(1));
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_set_o |=> !top_set_o);

  generate
    if (SAT) begin : g_sat
      a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q == CNT_MAX && !clr_i |=> cnt_q == CNT_MAX);
    end else begin : g_roll
      a_r8_rollover: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q == CNT_MAX && inc_i && !clr_i |=> cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/phy_pe_detect.sv
module phy_pe_detect
  import phy_irq_pkg::*;
#(
  parameter int IDLE_RUN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       speed100_i,
  input  logic       sym_valid_i,
  input  logic [2:0] sym_class_i,
  output logic       hit_o
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_RUN - 1);

  logic             armed_q;
  logic [RUN_W-1:0] run_q;
  logic             act;

  assign act   = speed100_i & sym_valid_i;
  assign hit_o = act && armed_q && sym_class_i == SYM_IDLE && run_q == RUN_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      run_q   <= '0;
    end else if (act) begin
      unique case (sym_class_i)
        SYM_SSD:  begin armed_q <= 1'b1; run_q <= '0; end
        SYM_ESD:  begin armed_q <= 1'b0; run_q <= '0; end
        SYM_DATA: run_q <= '0;
        SYM_IDLE: begin
          if (hit_o) begin
            armed_q <= 1'b0;
            run_q   <= '0;
          end else if (armed_q) begin
            run_q <= run_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  a_r5_esd_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && sym_class_i == SYM_ESD |=> !armed_q);
  a_r5_hit_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !armed_q);
  a_r5_data_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && sym_class_i == SYM_DATA |=> run_q == '0);
endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
  import phy_irq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int IDLE_RUN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cim_unstable_i,
  input  logic              link_chg_i,
  input  logic              lock_chg_i,
  input  logic              disc_evt_i,
  input  logic              fcar_evt_i,
  input  logic              rxerr_evt_i,
  input  logic              speed100_i,
  input  logic              sym_valid_i,
  input  logic [2:0]        sym_class_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int NCNT = 3;

  logic [DATA_W-1:0] status_q, set_vec;
  logic              clr_stat, pe_hit;
  logic [NCNT-1:0]   cnt_inc, cnt_clr, cnt_top;
  logic [CNT_W-1:0]  cnt_val [NCNT];

  localparam logic [ADDR_W-1:0] CNT_ADDR [NCNT] = '{ADDR_DISC, ADDR_FCAR, ADDR_RXERR};
  localparam bit               CNT_SAT  [NCNT] = '{1'b0, 1'b1, 1'b0};

  assign cnt_inc = {rxerr_evt_i, fcar_evt_i, disc_evt_i};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign cnt_clr[i] = rd_i && addr_i == CNT_ADDR[i];
    phy_evt_counter #(.W(CNT_W), .SAT(CNT_SAT[i])) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (cnt_inc[i]),
      .clr_i     (cnt_clr[i]),
      .cnt_o     (cnt_val[i]),
      .top_set_o (cnt_top[i])
    );
  end

  phy_pe_detect #(.IDLE_RUN(IDLE_RUN)) u_pe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed100_i  (speed100_i),
    .sym_valid_i (sym_valid_i),
    .sym_class_i (sym_class_i),
    .hit_o       (pe_hit)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_CIM]   = cim_unstable_i;
    set_vec[BIT_LINK]  = link_chg_i;
    set_vec[BIT_LOCK]  = lock_chg_i;
    set_vec[BIT_PEND]  = pe_hit;
    set_vec[BIT_DISC]  = cnt_top[0];
    set_vec[BIT_FCAR]  = cnt_top[1];
    set_vec[BIT_RXERR] = cnt_top[2];
  end

  assign clr_stat = rd_i && addr_i == ADDR_STAT;

  // new events take priority over the read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (clr_stat ? '0 : status_q) | set_vec;
  end

  assign irq_o = |status_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_STAT:  rdata_o = status_q;
        ADDR_DISC:  rdata_o = DATA_W'(cnt_val[0]);
        ADDR_FCAR:  rdata_o = DATA_W'(cnt_val[1]);
        ADDR_RXERR: rdata_o = DATA_W'(cnt_val[2]);
        default:    rdata_o = '0;
      endcase
    end
  end

  a_r4_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stat && set_vec != '0 |=> (status_q & $past(set_vec)) == $past(set_vec));
  a_r2_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stat && set_vec == '0 |=> !irq_o);
  a_r3_link_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_chg_i |=> status_q[BIT_LINK] && irq_o);
  a_r1_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_STAT |-> rdata_o[8:0] == '0);
endmodule

// File: tb/phy_irq_unit_test.sv
`timescale 1ns/1ps
module phy_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cim = 0, lnk = 0, lck = 0, disc = 0, fcar = 0, rxe = 0;
  logic        spd = 1'b1, sv = 1'b0;
  logic [2:0]  sc = 3'd0;
  logic        rd = 1'b0;
  logic [4:0]  addr = 5'd0;
  logic [15:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  phy_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .cim_unstable_i(cim), .link_chg_i(lnk),
    .lock_chg_i(lck), .disc_evt_i(disc), .fcar_evt_i(fcar), .rxerr_evt_i(rxe),
    .speed100_i(spd), .sym_valid_i(sv), .sym_class_i(sc), .rd_i(rd),
    .addr_i(addr), .rdata_o(rdata), .irq_o(irq)
  );

  // {cim, link, lock} strobe -> expected status word
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {3'b100, 16'h8000}, {3'b010, 16'h4000}, {3'b001, 16'h2000},
    {3'b111, 16'hE000}, {3'b101, 16'hA000}, {3'b000, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic rdreg(input logic [4:0] a, output logic [15:0] d);
    rd = 1'b1; addr = a; #1; d = rdata;
    tick(); rd = 1'b0; addr = 5'd0;
  endtask

  task automatic sym(input logic [2:0] c);
    sv = 1'b1; sc = c; tick(); sv = 1'b0; sc = 3'd0;
  endtask

  initial begin
    #950000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    // R9: reset state
    rdreg(5'h11, v); chk("R9 status", v, 16'h0);
    rdreg(5'h12, v); chk("R9 disc", v, 16'h0);
    rdreg(5'h13, v); chk("R9 fcar", v, 16'h0);
    rdreg(5'h15, v); chk("R9 rxerr", v, 16'h0);
    chk("R9 irq", {15'd0, irq}, 16'h0);
    rst_n = 1'b1; tick();

    // R3/R1 vector walk
    for (int i = 0; i < NV; i++) begin
      {cim, lnk, lck} = VEC[i][18:16]; tick(); {cim, lnk, lck} = 3'b000;
      chk("R2 irq level", {15'd0, irq}, {15'd0, VEC[i][15:0] != 16'h0});
      rdreg(5'h11, v); chk("R3 status", v, VEC[i][15:0]);
    end

    // R2: read clears, irq drops
    lnk = 1'b1; tick(); lnk = 1'b0;
    rdreg(5'h11, v); chk("R2 first read", v, 16'h4000);
    chk("R2 irq cleared", {15'd0, irq}, 16'h0);
    rdreg(5'h11, v); chk("R2 second read", v, 16'h0);

    // R1: unused address reads 0 even with status pending
    cim = 1'b1; tick(); cim = 1'b0;
    rdreg(5'h14, v); chk("R1 unused addr", v, 16'h0);
    rdreg(5'h11, v); chk("R1 cim bit15", v, 16'h8000);

    // R4: event during read survives
    lck = 1'b1; rd = 1'b1; addr = 5'h11; #1; v = rdata;
    tick(); lck = 1'b0; rd = 1'b0;
    chk("R4 same-cycle read", v, 16'h0);
    rdreg(5'h11, v); chk("R4 kept", v, 16'h2000);

    // R5: premature end cases
    sym(3'd3); sym(3'd1); sym(3'd2); sym(3'd2);
    rdreg(5'h11, v); chk("R5 ssd data idle idle", v, 16'h1000);
    sym(3'd3); sym(3'd2); sym(3'd1); sym(3'd2); sym(3'd4); sym(3'd2); sym(3'd2);
    rdreg(5'h11, v); chk("R5 data restart / esd disarm", v, 16'h0);
    sym(3'd2); sym(3'd2);
    rdreg(5'h11, v); chk("R5 not armed", v, 16'h0);
    spd = 1'b0; sym(3'd3); sym(3'd2); sym(3'd2); spd = 1'b1;
    rdreg(5'h11, v); chk("R5 10M ignored", v, 16'h0);
    sym(3'd3); sym(3'd2); sym(3'd0); sym(3'd2);
    rdreg(5'h11, v); chk("R5 other code no effect", v, 16'h1000);

    // R6: counting and clear on read
    for (int i = 0; i < 5; i++) begin disc = 1'b1; tick(); end
    disc = 1'b0;
    rdreg(5'h12, v); chk("R6 disc count", v, 16'd5);
    rdreg(5'h12, v); chk("R6 disc cleared", v, 16'd0);
    rxe = 1'b1; tick(); tick(); rd = 1'b1; addr = 5'h15; #1; v = rdata;
    tick(); rxe = 1'b0; rd = 1'b0;
    chk("R6 read value", v, 16'd2);
    rdreg(5'h15, v); chk("R6 read+inc leaves 1", v, 16'd1);
    rdreg(5'h15, v);

    // R7/R8: long run on all three counters
    {disc, fcar, rxe} = 3'b111;
    for (int i = 0; i < 32768; i++) tick();
    {disc, fcar, rxe} = 3'b000; tick(); tick();
    chk("R7 irq", {15'd0, irq}, 16'h1);
    rdreg(5'h11, v); chk("R7 top bits", v, 16'h0E00);
    {disc, fcar, rxe} = 3'b111;
    for (int i = 0; i < 32767; i++) tick();
    {disc, fcar, rxe} = 3'b000; tick(); tick();
    rdreg(5'h11, v); chk("R7 no re-set while high", v, 16'h0);
    {disc, fcar, rxe} = 3'b111; tick(); tick();
    {disc, fcar, rxe} = 3'b000; tick(); tick();
    rdreg(5'h12, v); chk("R8 disc wraps", v, 16'd1);
    rdreg(5'h15, v); chk("R8 rxerr wraps", v, 16'd1);
    rdreg(5'h13, v); chk("R8 fcar saturates", v, 16'hFFFF);
    rdreg(5'h11, v); chk("R7 wrap sets nothing", v, 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule